// File: doc/BRIEF.md
# Partitioned Dual-Port Shared SRAM

This block is an on-chip SRAM bank shared by an 8-bit processor and a programmable-logic fabric. Each side has its own port with its own clock, a 16-bit byte address, 8-bit write data, an access strobe and a write strobe. Both ports can reach the bank in the same cycle. The physical bank is cut into equal chunks. A partition value, held in the processor clock domain, gives the number of chunks used as program storage. The remaining chunks, always at least one, form the data region. The processor reads program storage as 16-bit little-endian instruction words and loads it with byte writes. Both ports see the data region as a flat byte space that starts at address 0.

The processor side also owns two controls. The first is a configuration enable, without which the partition cannot change. The second is an inhibit bit that blocks every write from the fabric. An attempted fabric write while the inhibit is active sets a sticky flag, which is returned to the processor clock domain. The chunk size and chunk count are parameters. The target configuration uses 4 KB chunks; a small default keeps elaboration light. Control values cross into the fabric clock domain through two-stage synchronisers, so the fabric side sees a change three of its clock edges after the processor side registers it.

Top module: `shared_sram_bank`

## Requirements
- R1: A data-space write from either port is readable from both ports. Read data appears on the port's read-data output at the clock edge that samples the read strobe, and it holds until the next read.
- R2: With a partition value p, data byte address a maps to physical byte p*CHUNK + a, and program byte address b maps to physical byte b.
- R3: A processor read in program space (prog=1, we=0) takes a word address w and returns {byte 2w+1, byte 2w} on cpu_rdata[15:0].
- R4: The data region spans (NCHUNK-p)*CHUNK bytes. A data access at or above that size reads 0x00 and its write is dropped, with no aliasing onto any other byte.
- R5: Program space spans p*CHUNK bytes. A program word read whose bytes fall outside it returns 0x0000, and a program byte write at or above p*CHUNK is dropped.
- R6: The partition register loads only when the configuration enable is 1 and the value is below NCHUNK. In every other case it keeps its value.
- R7: Reset sets the partition to NCHUNK-1, which gives the smallest data region (one chunk). Reset also clears the inhibit bit, the violation flag and both read-data outputs.
- R8: While the inhibit is set, fabric writes leave memory unchanged. Fabric reads and processor writes still work. The inhibit takes effect at the third fabric clock edge after the processor edge that sets it.
- R9: A fabric write attempt while the inhibit is active sets fab_blocked, which stays 1 until reset. The flag reaches the processor domain two processor clock edges after it is set.
- R10: When both ports write the same physical byte at the same clock edge, the processor's byte is stored. Writes to different bytes at the same edge are both stored.
- R11: Data-space reads on the processor port return {8'h00, byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| cpu_clk | input | 1 | Processor port clock |
| cpu_en | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write strobe (1 = write) |
| cpu_prog | input | 1 | Processor address space: 0 = data, 1 = program |
| cpu_addr | input | 16 | Processor byte address (word address for program reads) |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 16 | Processor read data |
| ctl_cfg_en | input | 1 | Configuration enable for partition changes |
| ctl_part_we | input | 1 | Partition register load strobe |
| ctl_part_val | input | PW | Requested number of program chunks |
| ctl_inh_we | input | 1 | Inhibit bit load strobe |
| ctl_inh_val | input | 1 | New inhibit value (1 blocks fabric writes) |
| fab_blocked | output | 1 | Sticky flag for blocked fabric writes, in the processor domain |
| fab_clk | input | 1 | Fabric port clock |
| fab_en | input | 1 | Fabric access strobe |
| fab_we | input | 1 | Fabric write strobe (1 = write) |
| fab_addr | input | 16 | Fabric data byte address |
| fab_wdata | input | 8 | Fabric write byte |
| fab_rdata | output | 8 | Fabric read data |

## Verification
Two functions can land on the same clock edge: a processor write and a fabric write aimed at one physical byte, and a processor write beside a fabric write to a neighbouring byte. The bench ties both port clocks to one generator and presents both writes in the same half-cycle. It then reads the bytes back from both ports. The same byte must hold the processor's value, and the neighbouring bytes must each hold their own writer's value. A second overlap comes from the inhibit: a blocked fabric write is judged by reading the byte from both ports and by watching the sticky flag arrive in the processor domain.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic {
    SPACE_DATA = 1'b0,
    SPACE_PROG = 1'b1
  } space_e;
endpackage

// File: rtl/spm_rst_sync.sv
module spm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/spm_addr_map.sv
module spm_addr_map
  import spm_pkg::*;
#(
  parameter int NCHUNK   = 6,
  parameter int CHUNK_AW = 6,
  parameter int PW       = $clog2(NCHUNK),
  parameter int MAW      = $clog2(NCHUNK << CHUNK_AW)
) (
  input  space_e           space,
  input  logic             word,
  input  logic [15:0]      addr,
  input  logic [PW-1:0]    part,
  output logic             hit,
  output logic [MAW-1:0]   phys
);
  localparam int TOTAL = NCHUNK << CHUNK_AW;

  logic [16:0] byte_a;
  logic [16:0] prog_lim;
  logic [16:0] data_lim;

  always_comb begin
    byte_a   = word ? {addr, 1'b0} : {1'b0, addr};
    prog_lim = 17'(part) << CHUNK_AW;
    data_lim = (17'(NCHUNK) - 17'(part)) << CHUNK_AW;
    if (space == SPACE_PROG) begin
      hit  = byte_a < prog_lim;
      phys = MAW'(byte_a);
    end else begin
      hit  = byte_a < data_lim;
      phys = MAW'(prog_lim + byte_a);
    end
  end

  // R2
  always_comb begin
    if (hit) begin
      hit_bound_chk: assert (int'(phys) < TOTAL);
    end
  end
endmodule

// File: rtl/spm_xor_mem.sv
module spm_xor_mem #(
  parameter int DEPTH = 384,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          a_clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [7:0]    a_wdata,
  input  logic [AW-1:0] a_raddr0,
  input  logic [AW-1:0] a_raddr1,
  output logic [7:0]    a_rd0,
  output logic [7:0]    a_rd1,
  input  logic          b_clk,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rd
);
  // Each bank has one writer; a byte's value is the XOR of both banks.
  logic [7:0] bank_a [DEPTH];
  logic [7:0] bank_b [DEPTH];

  always_ff @(posedge a_clk) begin
    if (a_we) bank_a[a_waddr] <= a_wdata ^ bank_b[a_waddr];
  end

  always_ff @(posedge b_clk) begin
    if (b_we) bank_b[b_addr] <= b_wdata ^ bank_a[b_addr];
  end

  always_comb begin
    a_rd0 = bank_a[a_raddr0] ^ bank_b[a_raddr0];
    a_rd1 = bank_a[a_raddr1] ^ bank_b[a_raddr1];
    b_rd  = bank_a[b_addr]   ^ bank_b[b_addr];
  end
endmodule

// File: rtl/shared_sram_bank.sv
module shared_sram_bank
  import spm_pkg::*;
#(
  parameter int   NCHUNK   = 6,
  parameter int   CHUNK_AW = 6,
  localparam int  PW       = $clog2(NCHUNK)
) (
  input  logic          rst_n,
  input  logic          cpu_clk,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic          cpu_prog,
  input  logic [15:0]   cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [15:0]   cpu_rdata,
  input  logic          ctl_cfg_en,
  input  logic          ctl_part_we,
  input  logic [PW-1:0] ctl_part_val,
  input  logic          ctl_inh_we,
  input  logic          ctl_inh_val,
  output logic          fab_blocked,
  input  logic          fab_clk,
  input  logic          fab_en,
  input  logic          fab_we,
  input  logic [15:0]   fab_addr,
  input  logic [7:0]    fab_wdata,
  output logic [7:0]    fab_rdata
);
  localparam int            TOTAL     = NCHUNK << CHUNK_AW;
  localparam int            MAW       = $clog2(TOTAL);
  localparam logic [PW-1:0] PART_RST  = PW'(NCHUNK - 1);

  // ---------------- processor domain ----------------
  logic          crst_n;
  logic [PW-1:0] part_q, part_d;
  logic          inh_q, inh_d;
  logic [15:0]   crd_q, crd_d;
  logic          cpu_hit;
  logic [MAW-1:0] cpu_phys;
  logic          cpu_rd, cpu_wr_go;
  logic [7:0]    cpu_b0, cpu_b1;

  spm_rst_sync u_crst (.clk(cpu_clk), .arst_n(rst_n), .srst_n(crst_n));

  spm_addr_map #(.NCHUNK(NCHUNK), .CHUNK_AW(CHUNK_AW), .PW(PW), .MAW(MAW)) u_cpu_map (
    .space (space_e'(cpu_prog)),
    .word  (cpu_prog & ~cpu_we),
    .addr  (cpu_addr),
    .part  (part_q),
    .hit   (cpu_hit),
    .phys  (cpu_phys)
  );

  always_comb begin
    cpu_rd    = cpu_en && !cpu_we;
    cpu_wr_go = cpu_en && cpu_we && cpu_hit;

    part_d = part_q;
    if (ctl_part_we && ctl_cfg_en && (int'(ctl_part_val) < NCHUNK)) part_d = ctl_part_val;
    inh_d = ctl_inh_we ? ctl_inh_val : inh_q;

    crd_d = crd_q;
    if (cpu_rd) begin
      if (!cpu_hit)     crd_d = 16'h0000;
      else if (cpu_prog) crd_d = {cpu_b1, cpu_b0};
      else              crd_d = {8'h00, cpu_b0};
    end
  end

  always_ff @(posedge cpu_clk or negedge crst_n) begin
    if (!crst_n) begin
      part_q <= PART_RST;
      inh_q  <= 1'b0;
      crd_q  <= 16'h0000;
    end else begin
      part_q <= part_d;
      inh_q  <= inh_d;
      crd_q  <= crd_d;
    end
  end

  assign cpu_rdata = crd_q;

  // R6
  part_lock_chk: assert property (@(posedge cpu_clk) disable iff (!crst_n)
    !ctl_cfg_en |=> $stable(part_q));
  // R6
  part_range_chk: assert property (@(posedge cpu_clk) disable iff (!crst_n)
    int'(part_q) < NCHUNK);
  // R4
  rd_zero_chk: assert property (@(posedge cpu_clk) disable iff (!crst_n)
    (cpu_rd && !cpu_hit) |=> cpu_rdata == 16'h0000);
  // R1
  rd_hold_chk: assert property (@(posedge cpu_clk) disable iff (!crst_n)
    !cpu_rd |=> $stable(cpu_rdata));

  // ---------------- fabric domain ----------------
  logic          frst_n;
  logic          inh_s;
  logic [PW-1:0] part_s;
  logic          fab_hit;
  logic [MAW-1:0] fab_phys;
  logic          fab_try, fab_clash, fab_wr_go;
  logic          viol_q, viol_d;
  logic [7:0]    frd_q, frd_d;
  logic [7:0]    fab_b;

  spm_rst_sync u_frst (.clk(fab_clk), .arst_n(rst_n), .srst_n(frst_n));

  spm_sync #(.W(PW + 1), .RST_VAL({1'b0, PART_RST})) u_ctl_sync (
    .clk   (fab_clk),
    .rst_n (frst_n),
    .d     ({inh_q, part_q}),
    .q     ({inh_s, part_s})
  );

  spm_addr_map #(.NCHUNK(NCHUNK), .CHUNK_AW(CHUNK_AW), .PW(PW), .MAW(MAW)) u_fab_map (
    .space (SPACE_DATA),
    .word  (1'b0),
    .addr  (fab_addr),
    .part  (part_s),
    .hit   (fab_hit),
    .phys  (fab_phys)
  );

  always_comb begin
    fab_try   = fab_en && fab_we;
    // Same-byte write at the same edge: the processor keeps the byte.
    fab_clash = cpu_wr_go && (cpu_phys == fab_phys);
    fab_wr_go = fab_try && fab_hit && !inh_s && !fab_clash;
    viol_d    = viol_q | (fab_try && inh_s);
    frd_d     = frd_q;
    if (fab_en && !fab_we) frd_d = fab_hit ? fab_b : 8'h00;
  end

  always_ff @(posedge fab_clk or negedge frst_n) begin
    if (!frst_n) begin
      viol_q <= 1'b0;
      frd_q  <= 8'h00;
    end else begin
      viol_q <= viol_d;
      frd_q  <= frd_d;
    end
  end

  assign fab_rdata = frd_q;

  spm_sync #(.W(1), .RST_VAL(1'b0)) u_flag_sync (
    .clk   (cpu_clk),
    .rst_n (crst_n),
    .d     (viol_q),
    .q     (fab_blocked)
  );

  // R9
  flag_set_chk: assert property (@(posedge fab_clk) disable iff (!frst_n)
    (fab_en && fab_we && inh_s) |=> viol_q);
  // R9
  flag_keep_chk: assert property (@(posedge fab_clk) disable iff (!frst_n)
    viol_q |=> viol_q);
  // R4
  fab_rd_zero_chk: assert property (@(posedge fab_clk) disable iff (!frst_n)
    (fab_en && !fab_we && !fab_hit) |=> fab_rdata == 8'h00);

  // ---------------- storage ----------------
  spm_xor_mem #(.DEPTH(TOTAL), .AW(MAW)) u_mem (
    .a_clk    (cpu_clk),
    .a_we     (cpu_wr_go),
    .a_waddr  (cpu_phys),
    .a_wdata  (cpu_wdata),
    .a_raddr0 (cpu_phys),
    .a_raddr1 (cpu_phys + MAW'(1)),
    .a_rd0    (cpu_b0),
    .a_rd1    (cpu_b1),
    .b_clk    (fab_clk),
    .b_we     (fab_wr_go),
    .b_addr   (fab_phys),
    .b_wdata  (fab_wdata),
    .b_rd     (fab_b)
  );

  // R10
  clash_free_chk: assert property (@(posedge fab_clk) disable iff (!frst_n)
    fab_wr_go |-> !(cpu_wr_go && (cpu_phys == fab_phys)));
endmodule

// File: tb/shared_sram_bank_test.sv
module shared_sram_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cpu_en, cpu_we, cpu_prog;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [15:0] cpu_rdata;
  logic        ctl_cfg_en, ctl_part_we, ctl_inh_we, ctl_inh_val;
  logic [2:0]  ctl_part_val;
  logic        fab_blocked;
  logic        fab_en, fab_we;
  logic [15:0] fab_addr;
  logic [7:0]  fab_wdata;
  logic [7:0]  fab_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  shared_sram_bank uut (
    .rst_n(rst_n), .cpu_clk(clk), .cpu_en(cpu_en), .cpu_we(cpu_we),
    .cpu_prog(cpu_prog), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ctl_cfg_en(ctl_cfg_en), .ctl_part_we(ctl_part_we),
    .ctl_part_val(ctl_part_val), .ctl_inh_we(ctl_inh_we), .ctl_inh_val(ctl_inh_val),
    .fab_blocked(fab_blocked), .fab_clk(clk), .fab_en(fab_en), .fab_we(fab_we),
    .fab_addr(fab_addr), .fab_wdata(fab_wdata), .fab_rdata(fab_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic prog, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_en = 1; cpu_we = 1; cpu_prog = prog; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_en = 0; cpu_we = 0;
  endtask

  task automatic cpu_rd(input logic prog, input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    cpu_en = 1; cpu_we = 0; cpu_prog = prog; cpu_addr = a;
    @(negedge clk);
    cpu_en = 0;
    v = cpu_rdata;
  endtask

  task automatic fab_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    fab_en = 1; fab_we = 1; fab_addr = a; fab_wdata = d;
    @(negedge clk);
    fab_en = 0; fab_we = 0;
  endtask

  task automatic fab_rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    fab_en = 1; fab_we = 0; fab_addr = a;
    @(negedge clk);
    fab_en = 0;
    v = fab_rdata;
  endtask

  task automatic set_part(input logic cfg, input logic [2:0] p);
    @(negedge clk);
    ctl_cfg_en = cfg; ctl_part_we = 1; ctl_part_val = p;
    @(negedge clk);
    ctl_part_we = 0; ctl_cfg_en = 0;
    idle(4);
  endtask

  task automatic set_inh(input logic v);
    @(negedge clk);
    ctl_inh_we = 1; ctl_inh_val = v;
    @(negedge clk);
    ctl_inh_we = 0;
    idle(4);
  endtask

  // Default geometry: 6 chunks of 64 bytes; reset partition 5 -> data region 64 bytes.
  task automatic t_reset();
    logic [15:0] v;
    chk("R7 cpu_rdata after reset", cpu_rdata, 16'h0000);
    chk("R7 fab_rdata after reset", {8'h00, fab_rdata}, 16'h0000);
    chk("R7 fab_blocked after reset", {15'h0, fab_blocked}, 16'h0000);
    cpu_wr(0, 16'd63, 8'h3F);
    cpu_rd(0, 16'd63, v);
    chk("R7 last byte of one-chunk data region", v, 16'h003F);
    cpu_rd(0, 16'd64, v);
    chk("R7 data region is one chunk", v, 16'h0000);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    logic [7:0]  b;
    cpu_wr(0, 16'd10, 8'hA5);
    fab_rd(16'd10, b);
    chk("R1 fabric sees processor write", {8'h00, b}, 16'h00A5);
    fab_wr(16'd20, 8'h3C);
    cpu_rd(0, 16'd20, v);
    chk("R1 R11 processor sees fabric write", v, 16'h003C);
    chk("R9 no flag without inhibit", {15'h0, fab_blocked}, 16'h0000);
  endtask

  task automatic t_prog();
    logic [15:0] v;
    cpu_wr(1, 16'd0, 8'h11);
    cpu_wr(1, 16'd1, 8'h22);
    cpu_rd(1, 16'd0, v);
    chk("R3 program word 0", v, 16'h2211);
    cpu_wr(1, 16'd318, 8'hAB);
    cpu_wr(1, 16'd319, 8'hCD);
    cpu_rd(1, 16'd159, v);
    chk("R3 last program word", v, 16'hCDAB);
    cpu_rd(1, 16'd160, v);
    chk("R5 program word past region", v, 16'h0000);
    cpu_wr(0, 16'd0, 8'h77);
    cpu_wr(1, 16'd320, 8'h99);
    cpu_rd(0, 16'd0, v);
    chk("R5 program write past region dropped", v, 16'h0077);
  endtask

  task automatic t_range();
    logic [15:0] v;
    logic [7:0]  b;
    cpu_wr(0, 16'd64, 8'h99);
    fab_wr(16'd64, 8'h55);
    cpu_rd(1, 16'd0, v);
    chk("R4 out-of-region writes do not alias", v, 16'h2211);
    cpu_rd(0, 16'd64, v);
    chk("R4 processor read past data region", v, 16'h0000);
    fab_rd(16'd100, b);
    chk("R4 fabric read past data region", {8'h00, b}, 16'h0000);
  endtask

  task automatic t_part();
    logic [15:0] v;
    logic [7:0]  b;
    cpu_wr(1, 16'd128, 8'h5A);
    set_part(0, 3'd2);
    cpu_rd(0, 16'd64, v);
    chk("R6 partition kept without config enable", v, 16'h0000);
    set_part(1, 3'd6);
    cpu_rd(0, 16'd64, v);
    chk("R6 partition kept for value >= NCHUNK", v, 16'h0000);
    set_part(1, 3'd2);
    cpu_rd(0, 16'd0, v);
    chk("R2 data 0 maps to chunk 2", v, 16'h005A);
    cpu_rd(0, 16'd192, v);
    chk("R2 data 192 maps to physical 320", v, 16'h0077);
    fab_rd(16'd255, b);
    chk("R2 fabric uses new partition", {8'h00, b}, 16'h003F);
    cpu_rd(0, 16'd256, v);
    chk("R4 data region now 256 bytes", v, 16'h0000);
    cpu_rd(1, 16'd0, v);
    chk("R2 program byte map unchanged", v, 16'h2211);
    cpu_rd(1, 16'd64, v);
    chk("R5 program region now 128 bytes", v, 16'h0000);
  endtask

  task automatic t_inhibit();
    logic [15:0] v;
    logic [7:0]  b;
    cpu_wr(0, 16'd5, 8'h12);
    set_inh(1);
    fab_wr(16'd5, 8'hEE);
    cpu_rd(0, 16'd5, v);
    chk("R8 fabric write blocked", v, 16'h0012);
    fab_rd(16'd5, b);
    chk("R8 fabric read under inhibit", {8'h00, b}, 16'h0012);
    idle(3);
    chk("R9 flag raised", {15'h0, fab_blocked}, 16'h0001);
    cpu_wr(0, 16'd5, 8'h34);
    cpu_rd(0, 16'd5, v);
    chk("R8 processor write under inhibit", v, 16'h0034);
    set_inh(0);
    chk("R9 flag sticky", {15'h0, fab_blocked}, 16'h0001);
    fab_wr(16'd5, 8'h56);
    cpu_rd(0, 16'd5, v);
    chk("R8 fabric write after inhibit cleared", v, 16'h0056);
  endtask

  task automatic t_clash();
    logic [15:0] v;
    logic [7:0]  b;
    @(negedge clk);
    cpu_en = 1; cpu_we = 1; cpu_prog = 0; cpu_addr = 16'd7; cpu_wdata = 8'hC1;
    fab_en = 1; fab_we = 1; fab_addr = 16'd7; fab_wdata = 8'hF2;
    @(negedge clk);
    cpu_en = 0; cpu_we = 0; fab_en = 0; fab_we = 0;
    cpu_rd(0, 16'd7, v);
    chk("R10 processor wins same byte", v, 16'h00C1);
    fab_rd(16'd7, b);
    chk("R10 fabric sees processor byte", {8'h00, b}, 16'h00C1);
    @(negedge clk);
    cpu_en = 1; cpu_we = 1; cpu_addr = 16'd8; cpu_wdata = 8'h81;
    fab_en = 1; fab_we = 1; fab_addr = 16'd9; fab_wdata = 8'h92;
    @(negedge clk);
    cpu_en = 0; cpu_we = 0; fab_en = 0; fab_we = 0;
    cpu_rd(0, 16'd8, v);
    chk("R10 processor byte beside fabric write", v, 16'h0081);
    cpu_rd(0, 16'd9, v);
    chk("R10 fabric byte beside processor write", v, 16'h0092);
  endtask

  initial begin
    rst_n = 0; cpu_en = 0; cpu_we = 0; cpu_prog = 0; cpu_addr = '0; cpu_wdata = '0;
    ctl_cfg_en = 0; ctl_part_we = 0; ctl_part_val = '0; ctl_inh_we = 0; ctl_inh_val = 0;
    fab_en = 0; fab_we = 0; fab_addr = '0; fab_wdata = '0;
    idle(3);
    rst_n = 1;
    idle(4);
    t_reset();
    t_basic();
    t_prog();
    t_range();
    t_part();
    t_inhibit();
    t_clash();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule